// File: doc/BRIEF.md
# PHY Link Bring-Up Sequencer

This block drives an Ethernet PHY from an unknown state to a settled link through a management (MDIO) transaction port, one transaction at a time. After a start pulse it reads the PHY identifier to confirm that a device answers. It then reads the basic status register. If the link is already up, it goes straight to decoding. Otherwise it advertises every 10/100 ability, restarts auto-negotiation, polls for negotiation completion and then polls for link. Polls are spaced by a programmable number of microsecond ticks, and each polling phase has its own retry limit.

The outcome is one result, marked by a single-cycle `seq_done` pulse. On success it carries a link flag and the speed and duplex bits for MAC configuration. On failure it carries an error code (1 no device, 2 negotiation timeout, 3 link down). The MDIO frame engine is outside this block. The engine sees a held request with register address, direction and write data, and answers with a one-cycle `mdio_done` that carries read data.

States:
- `ST_IDLE` goes to `ST_RD_ID` on start.
- `ST_RD_ID` goes to `ST_IDLE` with error 1 when no device answers, and to `ST_RD_STAT` otherwise.
- `ST_RD_STAT` goes to `ST_IDLE` with success when the link is up, and to `ST_WR_ADV` when it is not.
- `ST_WR_ADV` goes to `ST_WR_CTRL`, and `ST_WR_CTRL` goes to `ST_AN_RD`.
- `ST_AN_RD` goes to `ST_LK_RD` when negotiation is complete, to `ST_IDLE` with error 2 on the last poll, and to `ST_AN_GAP` otherwise. `ST_AN_GAP` returns to `ST_AN_RD` when the pacing interval expires.
- `ST_LK_RD` goes to `ST_IDLE` with success when the link is up, to `ST_IDLE` with error 3 on the last poll, and to `ST_LK_GAP` otherwise. `ST_LK_GAP` returns to `ST_LK_RD` when the pacing interval expires.

Top module: `phy_linkup_seq`

## Requirements
- R1: After reset, `mdio_req`, `seq_done`, `link_up`, `speed_100` and `full_duplex` are 0 and `err_code` is 0.
- R2: A start pulse in idle first issues a read of register 2 at address `PHY_ADDR`; a start pulse while a sequence runs is ignored, so the transaction count and the result do not change.
- R3: A value of 0xFFFF from register 2 ends the sequence with `err_code` 1 after exactly one transaction.
- R4: If bit 2 (link) of register 1 is set on the first status read, no write is issued and the sequence ends successfully after exactly two reads.
- R5: Otherwise the block writes 0x01E1 to register 4 (selector 1 plus the four 10/100 half/full abilities in bits 8..5), then writes 0x1200 to register 0 (auto-negotiation enable in bit 12, restart in bit 9), in that order.
- R6: Register 1 is then read until bit 5 (negotiation complete) is set, at most `AN_POLLS` times; if it never sets, the result is `err_code` 2. Successive polls are at least `PACE_TICKS` ticks of `us_tick` apart.
- R7: After negotiation, register 1 is read until bit 2 is set, at most `LINK_POLLS` times, paced the same way; if it never sets, the result is `err_code` 3.
- R8: Speed and duplex are taken from the status read that showed the link, in this priority: bit 14 (100 full) gives speed 1 and duplex 1; otherwise bit 12 (10 full) gives 0/1; otherwise bit 13 (100 half) gives 1/0; otherwise 0/0.
- R9: At most one request is outstanding: once raised, `mdio_req` stays high with stable address, direction and data until `mdio_done`.
- R10: `seq_done` is a one-cycle pulse. `link_up` is 1 only with `err_code` 0, and speed and duplex are 0 on any error. The results hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up sequence (accepted in idle only) |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| mdio_req | output | 1 | Management transaction request, held until done |
| mdio_wr | output | 1 | 1 for write, 0 for read |
| mdio_phy | output | 5 | PHY address of the transaction |
| mdio_reg | output | 5 | Register address of the transaction |
| mdio_wdata | output | 16 | Write data |
| mdio_done | input | 1 | Transaction complete, one cycle |
| mdio_rdata | input | 16 | Read data, valid with `mdio_done` |
| link_up | output | 1 | Link established |
| speed_100 | output | 1 | 1 for 100 Mb/s, 0 for 10 Mb/s |
| full_duplex | output | 1 | 1 for full duplex |
| err_code | output | 2 | 0 success, 1 no PHY, 2 negotiation timeout, 3 link down |
| seq_done | output | 1 | One-cycle pulse when a result is posted |

## Verification
The assertions check on every cycle that:
- a request holds steady until its done;
- the result pulse lasts one cycle;
- a link flag never appears with an error code;
- a gap state is left only on a tick;
- an absent device or an early link posts the right result one cycle later.

Only the bench scenarios can show the rest, because each depends on whole sequences of status values from a modelled PHY:
- the exact number of polls before each timeout;
- the order and values of the two writes;
- the speed and duplex priority when several ability bits are set at once;
- that a second start in mid-sequence leaves no trace.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

    localparam logic [4:0]  REG_CTRL  = 5'd0;
    localparam logic [4:0]  REG_STAT  = 5'd1;
    localparam logic [4:0]  REG_ID1   = 5'd2;
    localparam logic [4:0]  REG_ADV   = 5'd4;

    localparam int          STAT_LINK = 2;
    localparam int          STAT_ANC  = 5;

    localparam logic [15:0] ADV_ALL    = 16'h01E1;
    localparam logic [15:0] CTRL_RENEG = 16'h1200;
    localparam logic [15:0] ID_ABSENT  = 16'hFFFF;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_NO_PHY  = 2'd1,
        ERR_AN_TOUT = 2'd2,
        ERR_NO_LINK = 2'd3
    } err_code_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_ID,
        ST_RD_STAT,
        ST_WR_ADV,
        ST_WR_CTRL,
        ST_AN_RD,
        ST_AN_GAP,
        ST_LK_RD,
        ST_LK_GAP
    } seq_state_t;

endpackage

// File: rtl/pbu_pace_timer.sv
module pbu_pace_timer #(
    parameter int PACE_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic us_tick,
    output logic expire
);
    localparam int CW = (PACE_TICKS > 1) ? $clog2(PACE_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PACE_TICKS - 1);

    logic [CW-1:0] cnt;

    assign expire = run && us_tick && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else if (us_tick) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pbu_poll_counter.sv
module pbu_poll_counter #(
    parameter int MAX_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic last
);
    localparam int CW = $clog2(MAX_POLLS + 1);
    localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);
    localparam logic [CW-1:0] TOP  = CW'(MAX_POLLS);

    logic [CW-1:0] cnt;

    assign last = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (bump && cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pbu_ability_resolve.sv
module pbu_ability_resolve (
    input  logic [3:0] ability,   // {100F, 100H, 10F, 10H}
    output logic       spd_100,
    output logic       fdx
);
    always_comb begin
        if (ability[3]) begin
            spd_100 = 1'b1; fdx = 1'b1;
        end else if (ability[1]) begin
            spd_100 = 1'b0; fdx = 1'b1;
        end else if (ability[2]) begin
            spd_100 = 1'b1; fdx = 1'b0;
        end else begin
            spd_100 = 1'b0; fdx = 1'b0;
        end
    end
endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
    import phy_bringup_pkg::*;
#(
    parameter logic [4:0] PHY_ADDR   = 5'd0,
    parameter int         PACE_TICKS = 100,
    parameter int         AN_POLLS   = 30000,
    parameter int         LINK_POLLS = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        us_tick,
    output logic        mdio_req,
    output logic        mdio_wr,
    output logic [4:0]  mdio_phy,
    output logic [4:0]  mdio_reg,
    output logic [15:0] mdio_wdata,
    input  logic        mdio_done,
    input  logic [15:0] mdio_rdata,
    output logic        link_up,
    output logic        speed_100,
    output logic        full_duplex,
    output logic [1:0]  err_code,
    output logic        seq_done
);
    seq_state_t state, nxt;
    logic       fin_valid;
    err_code_t  fin_code;
    logic       an_last, lk_last, gap_expire, gap_run;
    logic       res_spd, res_fdx;

    assign gap_run = (state == ST_AN_GAP) || (state == ST_LK_GAP);

    pbu_pace_timer #(.PACE_TICKS(PACE_TICKS)) u_pace (
        .clk(clk), .rst_n(rst_n), .run(gap_run), .us_tick(us_tick), .expire(gap_expire)
    );

    pbu_poll_counter #(.MAX_POLLS(AN_POLLS)) u_an_cnt (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE),
        .bump(state == ST_AN_RD && mdio_done), .last(an_last)
    );

    pbu_poll_counter #(.MAX_POLLS(LINK_POLLS)) u_lk_cnt (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE),
        .bump(state == ST_LK_RD && mdio_done), .last(lk_last)
    );

    pbu_ability_resolve u_resolve (
        .ability({mdio_rdata[14], mdio_rdata[13], mdio_rdata[12], mdio_rdata[11]}),
        .spd_100(res_spd), .fdx(res_fdx)
    );

    // next state and result decision
    always_comb begin
        nxt       = state;
        fin_valid = 1'b0;
        fin_code  = ERR_NONE;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_RD_ID;
            ST_RD_ID:   if (mdio_done) begin
                            if (mdio_rdata == ID_ABSENT) begin
                                nxt = ST_IDLE; fin_valid = 1'b1; fin_code = ERR_NO_PHY;
                            end else begin
                                nxt = ST_RD_STAT;
                            end
                        end
            ST_RD_STAT: if (mdio_done) begin
                            if (mdio_rdata[STAT_LINK]) begin
                                nxt = ST_IDLE; fin_valid = 1'b1;
                            end else begin
                                nxt = ST_WR_ADV;
                            end
                        end
            ST_WR_ADV:  if (mdio_done) nxt = ST_WR_CTRL;
            ST_WR_CTRL: if (mdio_done) nxt = ST_AN_RD;
            ST_AN_RD:   if (mdio_done) begin
                            if (mdio_rdata[STAT_ANC]) begin
                                nxt = ST_LK_RD;
                            end else if (an_last) begin
                                nxt = ST_IDLE; fin_valid = 1'b1; fin_code = ERR_AN_TOUT;
                            end else begin
                                nxt = ST_AN_GAP;
                            end
                        end
            ST_AN_GAP:  if (gap_expire) nxt = ST_AN_RD;
            ST_LK_RD:   if (mdio_done) begin
                            if (mdio_rdata[STAT_LINK]) begin
                                nxt = ST_IDLE; fin_valid = 1'b1;
                            end else if (lk_last) begin
                                nxt = ST_IDLE; fin_valid = 1'b1; fin_code = ERR_NO_LINK;
                            end else begin
                                nxt = ST_LK_GAP;
                            end
                        end
            ST_LK_GAP:  if (gap_expire) nxt = ST_LK_RD;
            default:    nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transaction outputs
    always_comb begin
        mdio_req   = 1'b0;
        mdio_wr    = 1'b0;
        mdio_reg   = REG_STAT;
        mdio_wdata = '0;
        mdio_phy   = PHY_ADDR;
        unique case (state)
            ST_RD_ID:                      begin mdio_req = 1'b1; mdio_reg = REG_ID1; end
            ST_RD_STAT, ST_AN_RD, ST_LK_RD: begin mdio_req = 1'b1; mdio_reg = REG_STAT; end
            ST_WR_ADV:  begin mdio_req = 1'b1; mdio_wr = 1'b1; mdio_reg = REG_ADV;  mdio_wdata = ADV_ALL;    end
            ST_WR_CTRL: begin mdio_req = 1'b1; mdio_wr = 1'b1; mdio_reg = REG_CTRL; mdio_wdata = CTRL_RENEG; end
            default: ;
        endcase
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_done    <= 1'b0;
            link_up     <= 1'b0;
            speed_100   <= 1'b0;
            full_duplex <= 1'b0;
            err_code    <= ERR_NONE;
        end else begin
            seq_done <= fin_valid;
            if (state == ST_IDLE && start) begin
                link_up     <= 1'b0;
                speed_100   <= 1'b0;
                full_duplex <= 1'b0;
                err_code    <= ERR_NONE;
            end else if (fin_valid) begin
                err_code    <= fin_code;
                link_up     <= (fin_code == ERR_NONE);
                speed_100   <= (fin_code == ERR_NONE) && res_spd;
                full_duplex <= (fin_code == ERR_NONE) && res_fdx;
            end
        end
    end

    a_r3_no_phy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_ID && mdio_done && mdio_rdata == ID_ABSENT) |=> (seq_done && err_code == 2'd1));
    a_r4_early_link: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_STAT && mdio_done && mdio_rdata[STAT_LINK]) |=> (seq_done && link_up));
    a_r6_an_gap_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AN_GAP && !us_tick) |=> (state == ST_AN_GAP));
    a_r7_lk_gap_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LK_GAP && !us_tick) |=> (state == ST_LK_GAP));
    a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_req && !mdio_done) |=> (mdio_req && $stable(mdio_reg) && $stable(mdio_wr) && $stable(mdio_wdata)));
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
    a_r10_link_ok: assert property (@(posedge clk) disable iff (!rst_n)
        link_up |-> (err_code == 2'd0));
endmodule

// File: tb/phy_linkup_seq_bench.sv
module phy_linkup_seq_bench;
    localparam logic [4:0] PHY_A = 5'd3;
    localparam int PACE  = 3;
    localparam int ANP   = 4;
    localparam int LKP   = 3;
    localparam int TDIV  = 4;

    typedef struct packed {
        logic [15:0] id;
        logic        lk;
        logic [7:0]  an;
        logic [7:0]  la;
        logic [3:0]  ab;    // {100F, 100H, 10F, 10H} -> status bits 14..11
        logic [1:0]  err;
        logic        spd;
        logic        fd;
        logic [7:0]  rd;
        logic        reneg;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{16'hFFFF, 1'b0, 8'd0,  8'd0, 4'b1111, 2'd1, 1'b0, 1'b0, 8'd1, 1'b0},
        '{16'h0022, 1'b1, 8'd0,  8'd0, 4'b1000, 2'd0, 1'b1, 1'b1, 8'd2, 1'b0},
        '{16'h0022, 1'b1, 8'd0,  8'd0, 4'b0111, 2'd0, 1'b0, 1'b1, 8'd2, 1'b0},
        '{16'h0022, 1'b1, 8'd0,  8'd0, 4'b0101, 2'd0, 1'b1, 1'b0, 8'd2, 1'b0},
        '{16'h0022, 1'b1, 8'd0,  8'd0, 4'b0001, 2'd0, 1'b0, 1'b0, 8'd2, 1'b0},
        '{16'h0022, 1'b1, 8'd0,  8'd0, 4'b0000, 2'd0, 1'b0, 1'b0, 8'd2, 1'b0},
        '{16'h0181, 1'b0, 8'd2,  8'd1, 4'b1111, 2'd0, 1'b1, 1'b1, 8'd7, 1'b1},
        '{16'h0181, 1'b0, 8'd10, 8'd0, 4'b1111, 2'd2, 1'b0, 1'b0, 8'd6, 1'b1},
        '{16'h0181, 1'b0, 8'd0,  8'd5, 4'b1111, 2'd3, 1'b0, 1'b0, 8'd6, 1'b1},
        '{16'h0181, 1'b0, 8'd3,  8'd2, 4'b0000, 2'd0, 1'b0, 1'b0, 8'd9, 1'b1},
        '{16'h0181, 1'b0, 8'd1,  8'd0, 4'b0110, 2'd0, 1'b0, 1'b1, 8'd5, 1'b1}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, us_tick = 1'b0;
    logic mdio_req, mdio_wr, mdio_done, link_up, speed_100, full_duplex, seq_done;
    logic [4:0] mdio_phy, mdio_reg;
    logic [15:0] mdio_wdata, mdio_rdata;
    logic [1:0] err_code;

    int n_chk = 0, n_fail = 0, cyc = 0, done_cnt = 0;
    vec_t cfg;
    int rd_cnt, wr_cnt, kpoll, t0, t1;
    bit ctrl_seen, phy_bad, first_seen, first_wr_seen;
    logic [4:0] first_reg, first_wr_reg;
    logic [15:0] adv_val, ctrl_val;

    always #2 clk = ~clk;

    phy_linkup_seq #(.PHY_ADDR(PHY_A), .PACE_TICKS(PACE), .AN_POLLS(ANP), .LINK_POLLS(LKP)) u_phy_linkup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
        .mdio_req(mdio_req), .mdio_wr(mdio_wr), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
        .mdio_wdata(mdio_wdata), .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
        .link_up(link_up), .speed_100(speed_100), .full_duplex(full_duplex),
        .err_code(err_code), .seq_done(seq_done)
    );

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) us_tick <= ((cyc % TDIV) == 0);
    always @(negedge clk) if (seq_done) done_cnt <= done_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] stat_val();
        logic [15:0] v = '0;
        v[14:11] = cfg.ab;
        if (!ctrl_seen) begin
            v[2] = cfg.lk;
        end else begin
            v[5] = (kpoll >= int'(cfg.an));
            v[2] = (kpoll >= int'(cfg.an) + 1 + int'(cfg.la));
        end
        return v;
    endfunction

    // PHY responder
    initial begin
        logic [15:0] val;
        mdio_done = 1'b0;
        mdio_rdata = '0;
        forever begin
            @(negedge clk);
            if (mdio_req) begin
                val = '0;
                if (mdio_phy != PHY_A) phy_bad = 1'b1;
                if (!first_seen) begin first_seen = 1'b1; first_reg = mdio_reg; end
                if (mdio_wr) begin
                    wr_cnt++;
                    if (!first_wr_seen) begin first_wr_seen = 1'b1; first_wr_reg = mdio_reg; end
                    if (mdio_reg == 5'd4) adv_val = mdio_wdata;
                    if (mdio_reg == 5'd0) begin ctrl_val = mdio_wdata; ctrl_seen = 1'b1; end
                end else begin
                    rd_cnt++;
                    if (mdio_reg == 5'd2) val = cfg.id;
                    else if (mdio_reg == 5'd1) begin
                        val = stat_val();
                        if (ctrl_seen) kpoll++;
                    end
                end
                @(negedge clk);
                mdio_done = 1'b1;
                mdio_rdata = val;
                @(negedge clk);
                mdio_done = 1'b0;
            end
        end
    end

    task automatic run_seq(input vec_t v, input bit extra_start);
        cfg = v; rd_cnt = 0; wr_cnt = 0; kpoll = 0; ctrl_seen = 0; phy_bad = 0;
        first_seen = 0; first_wr_seen = 0; first_reg = '1; first_wr_reg = '1;
        adv_val = '0; ctrl_val = '0;
        @(negedge clk); start = 1'b1; t0 = cyc;
        @(negedge clk); start = 1'b0;
        if (extra_start) begin
            repeat (12) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!seq_done) @(negedge clk);
        t1 = cyc;
        repeat (20) @(negedge clk);
    endtask

    task automatic check_vec(input vec_t v);
        int gaps;
        check("R2 first register", int'(first_reg), 2);
        check("R2 phy address", int'(phy_bad), 0);
        check(v.err == 2'd1 ? "R3 error code" : v.err == 2'd2 ? "R6 error code" :
              v.err == 2'd3 ? "R7 error code" : "R4 error code", int'(err_code), int'(v.err));
        check("R10 link flag", int'(link_up), int'(v.err == 2'd0));
        check("R8 speed", int'(speed_100), int'(v.spd));
        check("R8 duplex", int'(full_duplex), int'(v.fd));
        check("R6 R7 read count", rd_cnt, int'(v.rd));
        if (v.reneg) begin
            check("R5 write count", wr_cnt, 2);
            check("R5 first write register", int'(first_wr_reg), 4);
            check("R5 advert value", int'(adv_val), 16'h01E1);
            check("R5 control value", int'(ctrl_val), 16'h1200);
            gaps = int'(v.rd) - 2 - ((v.err == 2'd2) ? 1 : 2);
            if (gaps > 0)
                check("R6 pacing lower bound", int'((t1 - t0) >= gaps * (PACE - 1) * TDIV), 1);
        end else begin
            check("R4 no writes", wr_cnt, 0);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int d0;
        repeat (3) @(negedge clk);
        check("R1 req after reset", int'(mdio_req), 0);
        check("R1 done after reset", int'(seq_done), 0);
        check("R1 link after reset", int'(link_up), 0);
        check("R1 err after reset", int'(err_code), 0);
        check("R1 speed/duplex after reset", int'({speed_100, full_duplex}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_seq(VEC[i], 1'b0);
            check_vec(VEC[i]);
        end

        // R2: start during a run is ignored
        d0 = done_cnt;
        run_seq(VEC[6], 1'b1);
        check_vec(VEC[6]);
        check("R2 single result for double start", done_cnt - d0, 1);
        check("R10 single done pulse", done_cnt - d0, 1);

        // R10: new start clears held result
        @(negedge clk); start = 1'b1; cfg = VEC[0]; rd_cnt = 0;
        @(negedge clk); start = 1'b0;
        check("R10 link cleared on start", int'(link_up), 0);
        check("R10 speed cleared on start", int'(speed_100), 0);
        while (!seq_done) @(negedge clk);
        @(negedge clk);
        check("R3 no-phy after success", int'(err_code), 1);
        check("R3 single transaction", rd_cnt, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule